// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides, in one combinational pass, whether an eight-line interrupt controller should raise its request to the processor and which line wins. It looks at the pending requests, the mask bits and the set of lines already in service. Priority is not fixed. A 3-bit rotation base names the line with the top priority, and the remaining lines follow it in ascending order, wrapping around.

A pending, unmasked request is forwarded only when it outranks every line that is currently in service. An instance configured as the upstream controller of a cascade can exclude the in-service bit of its cascade input from that comparison. This lets a downstream controller pass a second, higher-priority request through the same input while the first is still being serviced.

As a helper for non-specific end-of-interrupt handling, the block also reports the highest-priority line in the full in-service set. The block holds no registers. Storage of the request, mask and in-service state, the command interface and the cascade wiring all sit outside it.

Top module: `rot_irq_resolver`

## Requirements
- R1: A line is a candidate only when its bit in `pend_i` is 1 and its bit in `mask_i` is 0. A masked line never wins.
- R2: Priority index p belongs to physical line (p + `rot_base_i`) mod 8, and a smaller p means higher priority. Among the candidates, the one with the smallest p is selected.
- R3: `irq_o` is 1 only when the selected candidate's index is strictly smaller than the index of the highest-priority line in the in-service set used for comparison. An empty set has index 8.
- R4: A candidate whose own line is the top in-service line is not forwarded, because equal priority does not raise.
- R5: When the parameter `IS_MASTER` is 1 and `nested_en_i` is 1, the in-service bit of line `CASCADE_LINE` (default 2) is left out of the comparison. When `nested_en_i` is 0, that bit takes part in the comparison like any other line.
- R6: When `irq_o` is 0, `win_line_o` is 0 and `win_onehot_o` is 0.
- R7: When `irq_o` is 1, `win_line_o` gives the winning line in binary, and `win_onehot_o` has exactly that bit set.
- R8: `isr_top_valid_o` is 1 when any bit of `insvc_i` is set. `isr_top_line_o` is then the highest-priority in-service line under the rotation base, taken over the full set with no cascade exclusion. When the set is empty, the line output is 0.
- R9: In an instance with `IS_MASTER` = 0, `nested_en_i` has no effect on `irq_o` or on the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_i | input | 8 | Pending request bits, one per line |
| mask_i | input | 8 | Mask bits; 1 blocks the line |
| insvc_i | input | 8 | In-service bits, one per line |
| rot_base_i | input | 3 | Line that currently has the top priority |
| nested_en_i | input | 1 | Enables the cascade-line exclusion (upstream instance only) |
| irq_o | output | 1 | Request to the processor |
| win_line_o | output | 3 | Winning line, binary |
| win_onehot_o | output | 8 | Winning line, one-hot |
| isr_top_valid_o | output | 1 | At least one line is in service |
| isr_top_line_o | output | 3 | Highest-priority in-service line |

## Verification
Single requests and full request vectors under partial masks separate the mask gating from the plain search. The same request sets are tried under several rotation bases, including ones where the wrap-around reverses the order of two lines, to show the search starts at the base and not at line 0. Pairs of in-service and pending lines that are above, equal to and below each other separate a strict comparison from a non-strict one. Cascade-line cases are run with the exclusion on and off, on an upstream instance and on a downstream instance, so the two controller roles are told apart. A long run of pseudo-random vectors then covers mixed masks, rotations and in-service sets.

// File: rtl/rot_irq_pkg.sv
package rot_irq_pkg;
  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_CASCADE = 2;
endpackage

// File: rtl/prio_rot_search.sv
// Lowest index p with vec_i[(p+base_i) mod N] set; prio_o = N when none.
module prio_rot_search #(
  parameter int unsigned N = rot_irq_pkg::DEF_LINES,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] base_i,
  output logic         hit_o,
  output logic [W:0]   prio_o,
  output logic [W-1:0] line_o
);
  logic [N-1:0] rot;

  for (genvar p = 0; p < N; p++) begin : g_rot
    logic [W-1:0] idx;
    assign idx    = W'(p) + base_i;
    assign rot[p] = vec_i[idx];
  end

  always_comb begin
    prio_o = (W+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot[p]) prio_o = (W+1)'(p);
    end
  end

  assign hit_o  = |vec_i;
  assign line_o = hit_o ? (prio_o[W-1:0] + base_i) : '0;

  always_comb begin
    if (hit_o) begin
      p_line_member_r2: assert (vec_i[line_o])
        else $error("search picked a clear line");
    end else begin
      p_sentinel_r3: assert (prio_o == (W+1)'(N))
        else $error("empty vector without sentinel");
    end
  end
endmodule

// File: rtl/prio_nest_filter.sv
// Drops the cascade line from the in-service set when nesting is enabled on a master.
module prio_nest_filter #(
  parameter int unsigned N            = rot_irq_pkg::DEF_LINES,
  parameter int unsigned CASCADE_LINE = rot_irq_pkg::DEF_CASCADE,
  parameter bit          IS_MASTER    = 1'b1
) (
  input  logic [N-1:0] insvc_i,
  input  logic         nested_en_i,
  output logic [N-1:0] insvc_o
);
  localparam logic [N-1:0] CASC_MASK = IS_MASTER ? (N'(1) << CASCADE_LINE) : '0;

  assign insvc_o = insvc_i & ~(CASC_MASK & {N{nested_en_i}});

  always_comb begin
    if (!IS_MASTER || !nested_en_i) begin
      p_pass_through_r5: assert (insvc_o == insvc_i)
        else $error("in-service set altered without nesting");
    end
  end
endmodule

// File: rtl/prio_line_decode.sv
module prio_line_decode #(
  parameter int unsigned N = rot_irq_pkg::DEF_LINES,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         en_i,
  input  logic [W-1:0] line_i,
  output logic [N-1:0] onehot_o
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign onehot_o[i] = en_i && (line_i == W'(i));
  end
endmodule

// File: rtl/rot_irq_resolver.sv
module rot_irq_resolver #(
  parameter int unsigned N            = rot_irq_pkg::DEF_LINES,
  parameter int unsigned CASCADE_LINE = rot_irq_pkg::DEF_CASCADE,
  parameter bit          IS_MASTER    = 1'b1,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] insvc_i,
  input  logic [W-1:0] rot_base_i,
  input  logic         nested_en_i,
  output logic         irq_o,
  output logic [W-1:0] win_line_o,
  output logic [N-1:0] win_onehot_o,
  output logic         isr_top_valid_o,
  output logic [W-1:0] isr_top_line_o
);
  logic [N-1:0] cand, insvc_cmp;
  logic         req_hit, cur_hit;
  logic [W:0]   req_prio, cur_prio, top_prio;
  logic [W-1:0] req_line, cur_line;

  assign cand = pend_i & ~mask_i;

  prio_rot_search #(.N(N)) u_req (
    .vec_i(cand), .base_i(rot_base_i),
    .hit_o(req_hit), .prio_o(req_prio), .line_o(req_line)
  );

  prio_nest_filter #(.N(N), .CASCADE_LINE(CASCADE_LINE), .IS_MASTER(IS_MASTER)) u_nest (
    .insvc_i(insvc_i), .nested_en_i(nested_en_i), .insvc_o(insvc_cmp)
  );

  prio_rot_search #(.N(N)) u_cur (
    .vec_i(insvc_cmp), .base_i(rot_base_i),
    .hit_o(cur_hit), .prio_o(cur_prio), .line_o(cur_line)
  );

  prio_rot_search #(.N(N)) u_top (
    .vec_i(insvc_i), .base_i(rot_base_i),
    .hit_o(isr_top_valid_o), .prio_o(top_prio), .line_o(isr_top_line_o)
  );

  assign irq_o      = req_hit && (req_prio < cur_prio);
  assign win_line_o = irq_o ? req_line : '0;

  prio_line_decode #(.N(N)) u_dec (
    .en_i(irq_o), .line_i(win_line_o), .onehot_o(win_onehot_o)
  );

  always_comb begin
    p_onehot_r7: assert ($onehot0(win_onehot_o))
      else $error("winner vector not one-hot");
    if (!irq_o) begin
      p_idle_r6: assert (win_line_o == '0 && win_onehot_o == '0)
        else $error("winner outputs active without irq");
    end else begin
      p_unmasked_r1: assert (pend_i[win_line_o] && !mask_i[win_line_o])
        else $error("winner is not an unmasked request");
      p_onehot_match_r7: assert (win_onehot_o[win_line_o])
        else $error("one-hot and binary winner differ");
      if (insvc_i[win_line_o]) begin
        p_nest_only_r5: assert (IS_MASTER && nested_en_i && win_line_o == W'(CASCADE_LINE))
          else $error("in-service line raised outside nesting");
      end
      if (cur_hit) begin
        p_beats_cur_r3: assert (cur_line != win_line_o)
          else $error("winner equals current priority line");
      end
    end
    if (isr_top_valid_o) begin
      p_top_member_r8: assert (insvc_i[isr_top_line_o] && top_prio < (W+1)'(N))
        else $error("top in-service line not in service");
    end
  end
endmodule

// File: tb/tb_rot_irq_resolver.sv
`timescale 1ns/1ps
module tb_rot_irq_resolver;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] pend, mask, insvc;
  logic [2:0] base;
  logic       nest;
  logic       irq_m, irq_s, isv_m, isv_s;
  logic [2:0] line_m, line_s, isl_m, isl_s;
  logic [7:0] oh_m, oh_s;

  rot_irq_resolver #(.IS_MASTER(1'b1)) dut (
    .pend_i(pend), .mask_i(mask), .insvc_i(insvc), .rot_base_i(base),
    .nested_en_i(nest), .irq_o(irq_m), .win_line_o(line_m), .win_onehot_o(oh_m),
    .isr_top_valid_o(isv_m), .isr_top_line_o(isl_m)
  );

  rot_irq_resolver #(.IS_MASTER(1'b0)) dut_slv (
    .pend_i(pend), .mask_i(mask), .insvc_i(insvc), .rot_base_i(base),
    .nested_en_i(nest), .irq_o(irq_s), .win_line_o(line_s), .win_onehot_o(oh_s),
    .isr_top_valid_o(isv_s), .isr_top_line_o(isl_s)
  );

  typedef struct {
    logic       irq;
    logic [2:0] line;
    logic [7:0] oh;
    logic       isv;
    logic [2:0] isl;
    logic       irq_s;
    logic [2:0] line_s;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic int rsearch(logic [7:0] v, logic [2:0] b);
    for (int p = 0; p < 8; p++) begin
      if (v[3'(p + int'(b))]) return p;
    end
    return 8;
  endfunction

  task automatic drive(logic [7:0] p, logic [7:0] m, logic [7:0] s,
                       logic [2:0] b, logic n, string tag);
    exp_t e;
    int rp, cp, cps, tp;
    logic [7:0] filt;
    @(negedge clk);
    pend = p; mask = m; insvc = s; base = b; nest = n;
    filt = n ? (s & 8'hFB) : s;
    rp  = rsearch(p & ~m, b);
    cp  = rsearch(filt, b);
    cps = rsearch(s, b);
    tp  = rsearch(s, b);
    e.irq    = rp < cp;
    e.line   = e.irq ? 3'(rp + int'(b)) : 3'd0;
    e.oh     = e.irq ? (8'd1 << e.line) : 8'd0;
    e.isv    = tp < 8;
    e.isl    = e.isv ? 3'(tp + int'(b)) : 3'd0;
    e.irq_s  = rp < cps;
    e.line_s = e.irq_s ? 3'(rp + int'(b)) : 3'd0;
    e.tag    = tag;
    q.push_back(e);
  endtask

  task automatic cmp(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "irq",       int'(irq_m),  int'(e.irq));
      cmp(e.tag, "line",      int'(line_m), int'(e.line));
      cmp(e.tag, "onehot",    int'(oh_m),   int'(e.oh));
      cmp(e.tag, "isr_valid", int'(isv_m),  int'(e.isv));
      cmp(e.tag, "isr_line",  int'(isl_m),  int'(e.isl));
      cmp(e.tag, "slv_irq",   int'(irq_s),  int'(e.irq_s));
      cmp(e.tag, "slv_line",  int'(line_s), int'(e.line_s));
    end
  end

  initial begin
    pend = '0; mask = '0; insvc = '0; base = '0; nest = 1'b0;
    drive(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, "R6 idle");
    drive(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, "R8 empty isr");
    drive(8'h01, 8'h00, 8'h00, 3'd0, 1'b0, "R2 single line0");
    drive(8'hFF, 8'h01, 8'h00, 3'd0, 1'b0, "R1 mask line0");
    drive(8'hFF, 8'hFE, 8'h00, 3'd3, 1'b0, "R1 only line0 open");
    drive(8'hFF, 8'hFF, 8'h00, 3'd0, 1'b0, "R1 all masked");
    drive(8'h31, 8'h00, 8'h00, 3'd5, 1'b0, "R2 base5 line5");
    drive(8'h11, 8'h00, 8'h00, 3'd5, 1'b0, "R2 wrap line0");
    drive(8'h80, 8'h00, 8'h00, 3'd7, 1'b0, "R7 line7 onehot");
    drive(8'h08, 8'h00, 8'h08, 3'd0, 1'b0, "R4 equal prio");
    drive(8'h02, 8'h00, 8'h08, 3'd0, 1'b0, "R3 higher raises");
    drive(8'h20, 8'h00, 8'h08, 3'd0, 1'b0, "R3 lower blocked");
    drive(8'h20, 8'h00, 8'h08, 3'd4, 1'b0, "R3 rotated higher");
    drive(8'h00, 8'h00, 8'h28, 3'd4, 1'b0, "R8 top isr line5");
    drive(8'h04, 8'h00, 8'h04, 3'd0, 1'b1, "R5 nest cascade again");
    drive(8'h04, 8'h00, 8'h04, 3'd0, 1'b0, "R5 no nest blocked");
    drive(8'h08, 8'h00, 8'h04, 3'd0, 1'b1, "R9 slave ignores nest");
    drive(8'h08, 8'h00, 8'h04, 3'd0, 1'b0, "R5 line3 blocked");
    drive(8'h04, 8'h00, 8'h05, 3'd0, 1'b1, "R5 other isr still blocks");
    for (int i = 0; i < 400; i++) begin
      drive(8'($urandom), 8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom),
            3'($urandom), 1'($urandom), "R2 R3 random");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule